// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block runs on the host side of a two-wire link to a 20-bit bridge-sensor converter. The converter has a single output line that does two jobs: it drops low to say a result is waiting, and after that it carries the result bits. The controller watches that line through a synchronizer. When the line drops, it drives serial clock pulses whose high and low phases each last a set number of cycles. It samples one bit per pulse, most significant bit first, and hands the 20-bit two's-complement word to a downstream consumer. The word is sign-extended to 32 bits and offered on a valid/ready stream.

Four plain command inputs, each a one-cycle pulse, shape the next readout. A calibration request adds six clocks after the data (26 in total), which tells the converter to run an offset calibration. A standby request leaves the clock parked high once the line next signals ready, and a later wake request drives it low again. An input-change request marks the next four results as unsettled, and the block reads them but does not deliver them. A level input selects polling mode, which adds a 21st clock so that the line is high again at once.

The output stream keeps one word. While a word waits (valid high, ready low), it stays unchanged. If a new word arrives before the consumer takes the old one, the new word replaces it and the overrun flag rises alongside it. There is no deeper buffering: the consumer must take each word within one conversion period.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the serial clock is low, out_valid is 0 and overrun is 0.
- R2: While the synchronized line stays high, no clock pulse is issued and the clock stays low.
- R3: A readout captures 20 bits, one per pulse, first bit = bit 19 (sign). The word is delivered as a 32-bit value whose bits 31..20 copy bit 19.
- R4: Each high phase and each low phase of a data pulse lasts at least HALF_CYC clock cycles. The line is sampled SAMPLE_DLY cycles into the high phase.
- R5: A plain readout issues exactly 20 pulses. With poll_mode_i = 1 it issues exactly 21.
- R6: After a readout, no new readout starts until the line has been seen high again. A line left low by a last bit of 0 therefore causes no second readout.
- R7: After a calibration request, the next readout issues exactly 26 pulses. The first result after that one is delivered even if results are still owed to the discard count, and the discard count is then cleared.
- R8: With a standby request pending, the next falling edge of the line makes the clock rise and stay high. No further pulses follow and no word is delivered. A wake request in standby drives the clock low, and later readouts work normally.
- R9: After an input-change request, the next DROP_N (4) readouts are performed but not delivered. The one after them is delivered.
- R10: A word with out_valid = 1 and out_ready_i = 0 stays valid. Its data changes only if a newer word replaces it, and in that case overrun_o = 1 along with the new word. overrun_o clears when a word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Converter ready/data line |
| sclk_o | output | 1 | Serial clock to the converter |
| poll_mode_i | input | 1 | Add a 21st pulse after each readout |
| cal_req_i | input | 1 | Pulse: request an offset calibration on the next readout |
| sleep_req_i | input | 1 | Pulse: park the converter in standby at the next ready |
| wake_req_i | input | 1 | Pulse: leave standby |
| input_chg_i | input | 1 | Pulse: the analog input changed, so discard unsettled results |
| out_valid_o | output | 1 | Stream word valid |
| out_ready_i | input | 1 | Stream consumer ready |
| out_data_o | output | 32 | Sign-extended sample |
| overrun_o | output | 1 | The current word replaced one that was never taken |

## Verification
The hardest case to reach from the ports is standby. The converter must stop answering clocks and hold its line high while the clock is parked, and the bench must then show that the clock stays high with no pulses and no delivered word. To get there, the converter model in the bench goes silent: it drops the line to signal ready, raises it once the clock is parked, and resumes normal answers only after the wake pulse. The discard and calibration interaction is reached by issuing an input change, running part of the discard count, and then requesting calibration. This shows that the result after the calibration readout cuts the discard count short.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_HI = 2'd0,
    ST_IDLE    = 2'd1,
    ST_READ    = 2'd2,
    ST_SLEEP   = 2'd3
  } rd_state_t;
endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= 1'b1;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_rd_sclk.sv
module adc_rd_sclk #(
  parameter int HALF_CYC   = 13,
  parameter int SAMPLE_DLY = 9,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] n_pulses,
  output logic             sclk,
  output logic             sample_stb,
  output logic [CNT_W-1:0] pulse_idx,
  output logic             done
);
  localparam int TMR_W = $clog2(HALF_CYC + 1);

  logic             busy;
  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sclk <= 1'b0;
      tmr  <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        sclk <= 1'b1;
        tmr  <= '0;
        cnt  <= '0;
      end else if (busy) begin
        if (tmr == TMR_W'(HALF_CYC - 1)) begin
          tmr <= '0;
          if (sclk) begin
            sclk <= 1'b0;
          end else if (cnt == n_pulses - 1'b1) begin
            busy <= 1'b0;
            done <= 1'b1;
            cnt  <= cnt + 1'b1;
          end else begin
            sclk <= 1'b1;
            cnt  <= cnt + 1'b1;
          end
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
    end
  end

  assign sample_stb = busy && sclk && (tmr == TMR_W'(SAMPLE_DLY));
  assign pulse_idx  = cnt;
endmodule

// File: rtl/adc_rd_out.sv
module adc_rd_out #(
  parameter int DATA_W = 20,
  parameter int OUT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data,
  output logic              overrun
);
  localparam int EXT_W = OUT_W - DATA_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      overrun   <= 1'b0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_data  <= {{EXT_W{push_data[DATA_W-1]}}, push_data};
      overrun   <= out_valid && !out_ready;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
      overrun   <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_rdout_ctrl.sv
module adc_rdout_ctrl #(
  parameter int DATA_W      = 20,
  parameter int OUT_W       = 32,
  parameter int HALF_CYC    = 13,
  parameter int SAMPLE_DLY  = 9,
  parameter int CAL_EXTRA   = 6,
  parameter int DROP_N      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  output logic             sclk_o,
  input  logic             poll_mode_i,
  input  logic             cal_req_i,
  input  logic             sleep_req_i,
  input  logic             wake_req_i,
  input  logic             input_chg_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [OUT_W-1:0] out_data_o,
  output logic             overrun_o
);
  import adc_rd_pkg::*;

  localparam int CNT_W  = $clog2(DATA_W + CAL_EXTRA + 1);
  localparam int DROP_W = $clog2(DROP_N + 1);
  localparam int GAP_W  = $clog2(HALF_CYC + 1);

  rd_state_t         state;
  logic              line_s;
  logic              cal_pend, sleep_pend, wake_pend;
  logic              cal_act, after_cal, sleep_hi;
  logic [DROP_W-1:0] drop_cnt;
  logic [GAP_W-1:0]  gap;
  logic [CNT_W-1:0]  n_lat;
  logic [DATA_W-1:0] shreg;
  logic              gen_sclk, gen_stb, gen_done, gen_start;
  logic [CNT_W-1:0]  gen_idx;
  logic              deliver, push;

  adc_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_i), .q(line_s)
  );

  assign gen_start = (state == ST_IDLE) && !line_s && !sleep_pend && (gap == '0);

  adc_rd_sclk #(.HALF_CYC(HALF_CYC), .SAMPLE_DLY(SAMPLE_DLY), .CNT_W(CNT_W)) u_sclk (
    .clk(clk), .rst_n(rst_n), .start(gen_start), .n_pulses(n_lat),
    .sclk(gen_sclk), .sample_stb(gen_stb), .pulse_idx(gen_idx), .done(gen_done)
  );

  // shift in one bit per pulse, MSB first; extra pulses are not captured
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     shreg <= '0;
    else if (gen_stb && (gen_idx < CNT_W'(DATA_W))) shreg <= {shreg[DATA_W-2:0], line_s};
  end

  assign deliver = after_cal || (drop_cnt == '0);
  assign push    = (state == ST_READ) && gen_done && deliver;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_WAIT_HI;
      cal_pend   <= 1'b0;
      sleep_pend <= 1'b0;
      wake_pend  <= 1'b0;
      cal_act    <= 1'b0;
      after_cal  <= 1'b0;
      sleep_hi   <= 1'b0;
      drop_cnt   <= '0;
      gap        <= GAP_W'(HALF_CYC);
      n_lat      <= CNT_W'(DATA_W);
    end else begin
      if (gap != '0) gap <= gap - 1'b1;
      case (state)
        ST_WAIT_HI: if (line_s) state <= ST_IDLE;
        ST_IDLE: begin
          if (!line_s && gap == '0) begin
            if (sleep_pend) begin
              sleep_hi   <= 1'b1;
              sleep_pend <= 1'b0;
              wake_pend  <= 1'b0;
              gap        <= GAP_W'(HALF_CYC);
              state      <= ST_SLEEP;
            end else begin
              cal_act  <= cal_pend;
              cal_pend <= 1'b0;
              n_lat    <= cal_pend    ? CNT_W'(DATA_W + CAL_EXTRA) :
                          poll_mode_i ? CNT_W'(DATA_W + 1) : CNT_W'(DATA_W);
              state    <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (gen_done) begin
            if (deliver) begin
              after_cal <= 1'b0;
              drop_cnt  <= '0;
            end else begin
              drop_cnt  <= drop_cnt - 1'b1;
            end
            if (cal_act) after_cal <= 1'b1;
            state <= ST_WAIT_HI;
          end
        end
        ST_SLEEP: begin
          if (wake_req_i) wake_pend <= 1'b1;
          if (wake_pend && gap == '0) begin
            sleep_hi <= 1'b0;
            gap      <= GAP_W'(HALF_CYC);
            state    <= ST_WAIT_HI;
          end
        end
        default: state <= ST_WAIT_HI;
      endcase
      if (cal_req_i)   cal_pend   <= 1'b1;
      if (sleep_req_i) sleep_pend <= 1'b1;
      if (input_chg_i) begin
        drop_cnt  <= DROP_W'(DROP_N);
        after_cal <= 1'b0;
      end
    end
  end

  assign sclk_o = gen_sclk | sleep_hi;

  adc_rd_out #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(shreg),
    .out_ready(out_ready_i), .out_valid(out_valid_o),
    .out_data(out_data_o), .overrun(overrun_o)
  );
endmodule

// File: rtl/adc_rdout_chk.sv
module adc_rdout_chk #(
  parameter int HALF_CYC = 13,
  parameter int DATA_W   = 20,
  parameter int OUT_W    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [OUT_W-1:0] out_data_o,
  input logic             overrun_o
);
  logic [15:0] hi_run, lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else if (sclk_o) begin
      lo_run <= '0;
      if (hi_run != 16'hFFFF) hi_run <= hi_run + 1'b1;
    end else begin
      hi_run <= '0;
      if (lo_run != 16'hFFFF) lo_run <= lo_run + 1'b1;
    end
  end

  // R4
  sclk_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> hi_run >= 16'(HALF_CYC));

  // R4
  sclk_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> lo_run >= 16'(HALF_CYC));

  // R3
  sign_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ((&out_data_o[OUT_W-1:DATA_W-1]) || !(|out_data_o[OUT_W-1:DATA_W-1])));

  // R10
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o);

  // R10
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> $stable(out_data_o) || overrun_o);

  // R10
  overrun_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> out_valid_o);
endmodule

bind adc_rdout_ctrl adc_rdout_chk #(.HALF_CYC(HALF_CYC), .DATA_W(DATA_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_o(sclk_o), .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i), .out_data_o(out_data_o), .overrun_o(overrun_o)
);

// File: tb/tb_adc_rdout_ctrl.sv
module tb_adc_rdout_ctrl;
  localparam int HALF = 13;
  localparam int DW   = 20;

  logic clk = 1'b0, rst_n = 1'b0, line = 1'b1;
  logic poll = 1'b0, cal = 1'b0, slp = 1'b0, wake = 1'b0, chg = 1'b0, ordy = 1'b1;
  logic sclk, ovalid, ovr;
  logic [31:0] odata;

  always #4 clk = ~clk;

  adc_rdout_ctrl dut (
    .clk(clk), .rst_n(rst_n), .line_i(line), .sclk_o(sclk),
    .poll_mode_i(poll), .cal_req_i(cal), .sleep_req_i(slp), .wake_req_i(wake),
    .input_chg_i(chg), .out_valid_o(ovalid), .out_ready_i(ordy),
    .out_data_o(odata), .overrun_o(ovr)
  );

  int checks = 0, fails = 0, rises = 0, ccnt = 0, hrun = 0, lrun = 0;
  logic [DW-1:0] cword = '0;
  bit model_off = 0, sclk_prev = 0;
  logic [32:0] expq[$];

  function automatic logic [31:0] sext(logic [DW-1:0] w);
    return {{(32-DW){w[DW-1]}}, w};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // converter model and port monitor, evaluated away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && !sclk_prev) begin
        rises++;
        if (!model_off) begin
          ccnt++;
          line = (ccnt <= DW) ? cword[DW-ccnt] : 1'b1;
        end
      end
      if (sclk != sclk_prev) begin
        if (sclk) chk(lrun >= HALF, "R4", "low phase cycles", 64'(lrun), 64'(HALF));
        else      chk(hrun >= HALF, "R4", "high phase cycles", 64'(hrun), 64'(HALF));
        hrun = 0;
        lrun = 0;
      end
      if (sclk) hrun++; else lrun++;
      if (ovalid && ordy) begin
        if (expq.size() == 0) chk(1'b0, "R9", "unexpected word", 64'(odata), 64'(0));
        else begin
          logic [32:0] e;
          e = expq.pop_front();
          chk({ovr, odata} == e, "R3", "delivered word {ovr,data}", 64'({ovr, odata}), 64'(e));
        end
      end
      sclk_prev = sclk;
    end
  end

  task automatic pulse_wait(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic present(logic [DW-1:0] w, int exp_p, bit del, string req);
    int r0;
    @(posedge clk); #1;
    r0 = rises;
    cword = w;
    ccnt = 0;
    if (del) expq.push_back({1'b0, sext(w)});
    line = 1'b0;
    pulse_wait((exp_p + 2) * 2 * HALF + 40);
    chk(rises - r0 == exp_p, req, "pulses in readout", 64'(rises - r0), 64'(exp_p));
    if (del && ordy) chk(expq.size() == 0, req, "word delivered", 64'(expq.size()), 64'(0));
    @(posedge clk); #1;
    line = 1'b1;
    pulse_wait(12);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int r0;
    pulse_wait(5);
    // R1 reset state
    chk(sclk == 1'b0, "R1", "sclk in reset", 64'(sclk), 64'(0));
    chk(ovalid == 1'b0, "R1", "valid in reset", 64'(ovalid), 64'(0));
    chk(ovr == 1'b0, "R1", "overrun in reset", 64'(ovr), 64'(0));
    @(posedge clk); #1 rst_n = 1'b1;
    pulse_wait(2);
    chk(sclk == 1'b0 && ovalid == 1'b0, "R1", "state after reset", 64'({sclk, ovalid}), 64'(0));
    // R2 line high: nothing happens
    pulse_wait(300);
    chk(rises == 0, "R2", "pulses while line high", 64'(rises), 64'(0));
    chk(sclk == 1'b0, "R2", "sclk idle level", 64'(sclk), 64'(0));

    // R5 plain readouts, R3 corner codes
    present(20'h12345, 20, 1, "R5");
    present(20'h7FFFF, 20, 1, "R3");
    present(20'h80000, 20, 1, "R6");   // last bit 0 leaves the line low: no second readout
    present(20'h00000, 20, 1, "R6");
    @(posedge clk); #1 poll = 1'b1;
    present(20'hFFFFF, 21, 1, "R5");
    present(20'h00001, 21, 1, "R5");

    // R9 discard after input change
    @(posedge clk); #1 chg = 1'b1; @(posedge clk); #1 chg = 1'b0;
    for (int i = 0; i < 4; i++) present(20'h11111 * (i + 1), 21, 0, "R9");
    present(20'hABCDE, 21, 1, "R9");

    // R7 calibration cuts the discard count short
    @(posedge clk); #1 chg = 1'b1; @(posedge clk); #1 chg = 1'b0;
    present(20'h22222, 21, 0, "R7");
    present(20'h33333, 21, 0, "R7");
    @(posedge clk); #1 cal = 1'b1; @(posedge clk); #1 cal = 1'b0;
    present(20'h44444, 26, 0, "R7");
    present(20'h5A5A5, 21, 1, "R7");
    present(20'hC3C3C, 21, 1, "R7");

    // R10 back-pressure and overrun
    @(posedge clk); #1 ordy = 1'b0;
    present(20'h0F0F0, 21, 0, "R10");
    chk(ovalid == 1'b1, "R10", "valid held", 64'(ovalid), 64'(1));
    chk(odata == sext(20'h0F0F0), "R10", "held data", 64'(odata), 64'(sext(20'h0F0F0)));
    chk(ovr == 1'b0, "R10", "no overrun yet", 64'(ovr), 64'(0));
    present(20'h9ABCD, 21, 0, "R10");
    chk(odata == sext(20'h9ABCD), "R10", "replaced data", 64'(odata), 64'(sext(20'h9ABCD)));
    chk(ovr == 1'b1, "R10", "overrun flag", 64'(ovr), 64'(1));
    expq.push_back({1'b1, sext(20'h9ABCD)});
    @(posedge clk); #1 ordy = 1'b1;
    pulse_wait(4);
    chk(ovalid == 1'b0 && ovr == 1'b0, "R10", "cleared after take", 64'({ovalid, ovr}), 64'(0));
    present(20'h01234, 21, 1, "R10");

    // R8 standby and wake
    @(posedge clk); #1 slp = 1'b1; @(posedge clk); #1 slp = 1'b0;
    model_off = 1;
    r0 = rises;
    @(posedge clk); #1 line = 1'b0;
    pulse_wait(40);
    @(posedge clk); #1 line = 1'b1;
    pulse_wait(400);
    chk(sclk == 1'b1, "R8", "sclk parked high", 64'(sclk), 64'(1));
    chk(rises - r0 == 1, "R8", "rises in standby", 64'(rises - r0), 64'(1));
    chk(ovalid == 1'b0, "R8", "no word in standby", 64'(ovalid), 64'(0));
    @(posedge clk); #1 wake = 1'b1; @(posedge clk); #1 wake = 1'b0;
    pulse_wait(HALF + 6);
    chk(sclk == 1'b0, "R8", "sclk low after wake", 64'(sclk), 64'(1'b0));
    model_off = 0;
    pulse_wait(40);
    present(20'h13579, 21, 1, "R8");

    chk(expq.size() == 0, "R3", "all expected words delivered", 64'(expq.size()), 64'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule